// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the per-bit timing events of a CAN node. A programmable prescaler divides the clock into time quanta, and ten quanta make one bit. A one-clock strobe marks the start of each bit, which is when the transmit path may change its output. A second strobe three-tenths of a bit before the end marks the point where both the transmit and receive paths read the bus.

The received bus level is synchronised and watched for falls from recessive (1) to dominant (0). When the bus has been quiet for a run of recessive sample points, the node counts as idle, and the next fall restarts the bit. Inside a frame, an early or late edge moves the quantum count by a single step. Two nodes with separate clocks therefore stay bit-aligned without a hard realignment in mid-frame.

Top module: `can_bit_timer`

## Requirements
- R1: With no bus edges, the time between consecutive `set_o` strobes is 10 quanta, and one quantum lasts `prescale`+1 clock cycles. A `prescale` value of 0 gives one clock per quantum.
- R2: `set_o` is high for exactly one clock when the quantum count enters quantum 0. `sample_o` is high for exactly one clock when it enters quantum 7. Without edges, `sample_o` follows `set_o` by 7 quanta and `set_o` follows `sample_o` by 3 quanta.
- R3: `set_o` and `sample_o` are never high together. Both are low while `rst` is high and in the first cycle after it is released.
- R4: `rx_in` passes through two synchronising flops before edge detection. A fall that is present before a rising clock edge is acted on at the third rising edge after it. Rises of `rx_in` never change the timing.
- R5: After reset the node is idle. While idle, a fall starts a new bit at the acting clock edge. `set_o` is high in that cycle, and `sample_o` follows exactly 7 quanta later.
- R6: When not idle, a fall seen in quantum e, with 1 ≤ e ≤ 6, moves the count back to e−1 and restarts the quantum. `sample_o` then comes (8−e) quanta after the acting edge.
- R7: When not idle, a fall seen in quantum 7, 8 or 9 moves the count forward by one and restarts the quantum. From 9 the count wraps to 0 at once, with `set_o` high in that cycle. From 8, `set_o` comes one quantum after the acting edge.
- R8: When not idle, a fall seen in quantum 0 leaves the timing unchanged.
- R9: A fall that restarts the bit ends the idle state. The node becomes idle again once `IDLE_BITS` consecutive sample points read recessive, and a dominant sample point resets that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale | input | PRESC_W | Clock cycles per quantum, minus one |
| rx_in | input | 1 | Received bus level, asynchronous (1 = recessive) |
| set_o | output | 1 | One-clock strobe at the start of quantum 0 |
| sample_o | output | 1 | One-clock strobe at the start of quantum 7 |

## Verification
The bench builds the block with `PRESC_W` = 4 and `IDLE_BITS` = 3. The short idle run lets the return to idle and a second hard restart happen within a few bits. Between edge tests, each stimulus keeps the recessive run below three, so the node stays inside a frame. Most edge scenarios run at a prescale of 1, two clocks per quantum. That places every fall mid-quantum, away from the tick, so each quantum 0, 1, 3, 6, 8 and 9 can be hit on purpose. Prescales of 0 and 3 cover the shortest quantum and a longer one.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int QUANTA   = 10;
  localparam int SET_Q    = 0;
  localparam int SAMPLE_Q = 7;
  localparam int QW       = $clog2(QUANTA);

  typedef logic [QW-1:0] quanta_t;

  typedef enum logic [1:0] {
    ADJ_NONE,
    ADJ_HARD,
    ADJ_BACK,
    ADJ_FWD
  } adj_e;
endpackage

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_sync,
  output logic rx_fall
);
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[SYNC_STAGES-1:0], rx_in};
  end

  assign rx_sync = chain[SYNC_STAGES-1];
  assign rx_fall = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [PRESC_W-1:0] div,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbt_quanta.sv
module cbt_quanta
  import can_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  logic    fall,
  input  logic    idle,
  output quanta_t q,
  output logic    restart,
  output logic    set_o,
  output logic    sample_o
);
  adj_e    adj;
  quanta_t q_nxt;
  quanta_t q_inc;
  logic    set_n;
  logic    sample_n;

  assign q_inc = (q == quanta_t'(QUANTA-1)) ? '0 : q + 1'b1;

  always_comb begin
    adj = ADJ_NONE;
    if (fall) begin
      if (idle)                         adj = ADJ_HARD;
      else if (q == quanta_t'(SET_Q))   adj = ADJ_NONE;
      else if (q < quanta_t'(SAMPLE_Q)) adj = ADJ_BACK;
      else                              adj = ADJ_FWD;
    end
  end

  assign restart = (adj != ADJ_NONE);

  always_comb begin
    q_nxt    = q;
    set_n    = 1'b0;
    sample_n = 1'b0;
    case (adj)
      ADJ_HARD: begin
        q_nxt = quanta_t'(SET_Q);
        set_n = 1'b1;
      end
      ADJ_BACK: q_nxt = q - 1'b1;
      ADJ_FWD: begin
        q_nxt    = q_inc;
        set_n    = (q_inc == quanta_t'(SET_Q));
        sample_n = (q_inc == quanta_t'(SAMPLE_Q));
      end
      default: begin
        if (tick) begin
          q_nxt    = q_inc;
          set_n    = (q_inc == quanta_t'(SET_Q));
          sample_n = (q_inc == quanta_t'(SAMPLE_Q));
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= quanta_t'(SET_Q);
      set_o    <= 1'b0;
      sample_o <= 1'b0;
    end else begin
      q        <= q_nxt;
      set_o    <= set_n;
      sample_o <= sample_n;
    end
  end
endmodule

// File: rtl/cbt_idle_mon.sv
module cbt_idle_mon #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic rx_sync,
  input  logic hard_sync,
  output logic idle
);
  localparam int IW = $clog2(IDLE_BITS + 1);
  logic [IW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle <= 1'b1;
      run  <= '0;
    end else if (hard_sync) begin
      idle <= 1'b0;
      run  <= '0;
    end else if (sample) begin
      if (!rx_sync) begin
        idle <= 1'b0;
        run  <= '0;
      end else if (!idle) begin
        if (run + 1'b1 == IW'(IDLE_BITS)) begin
          idle <= 1'b1;
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int PRESC_W     = 8,
  parameter int IDLE_BITS   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               rx_in,
  output logic               set_o,
  output logic               sample_o
);
  logic    rx_sync;
  logic    rx_fall;
  logic    tq_tick;
  logic    restart;
  logic    is_idle;
  quanta_t q_cur;

  cbt_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_in(rx_in), .rx_sync(rx_sync), .rx_fall(rx_fall)
  );

  cbt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .restart(restart), .div(prescale), .tick(tq_tick)
  );

  cbt_quanta u_quanta (
    .clk(clk), .rst(rst), .tick(tq_tick), .fall(rx_fall), .idle(is_idle),
    .q(q_cur), .restart(restart), .set_o(set_o), .sample_o(sample_o)
  );

  cbt_idle_mon #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .sample(sample_o), .rx_sync(rx_sync),
    .hard_sync(rx_fall && is_idle), .idle(is_idle)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
  import can_bt_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    set_o,
  input logic    sample_o,
  input quanta_t q,
  input logic    idle,
  input logic    fall,
  input logic    tick
);
  assert_q_range_R1: assert property (@(posedge clk) disable iff (rst)
    q < quanta_t'(QUANTA));

  assert_set_at_q0_R2: assert property (@(posedge clk) disable iff (rst)
    set_o |-> q == quanta_t'(SET_Q));

  assert_sample_at_q7_R2: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> q == quanta_t'(SAMPLE_Q));

  assert_sample_single_R2: assert property (@(posedge clk) disable iff (rst)
    sample_o |=> !sample_o);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(set_o && sample_o));

  assert_hard_sync_R5: assert property (@(posedge clk) disable iff (rst)
    (fall && idle) |=> (set_o && q == quanta_t'(SET_Q)));

  assert_late_back_R6: assert property (@(posedge clk) disable iff (rst)
    (fall && !idle && q > 0 && q < quanta_t'(SAMPLE_Q)) |=> q == $past(q) - 1'b1);

  assert_early_fwd_R7: assert property (@(posedge clk) disable iff (rst)
    (fall && !idle && q >= quanta_t'(SAMPLE_Q)) |=>
      q == (($past(q) == quanta_t'(QUANTA-1)) ? quanta_t'(0) : $past(q) + 1'b1));

  assert_q0_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (fall && !idle && q == 0 && !tick) |=> q == 0);

  assert_idle_end_R9: assert property (@(posedge clk) disable iff (rst)
    (fall && idle) |=> !idle);
endmodule

bind can_bit_timer cbt_checker u_chk (
  .clk(clk), .rst(rst), .set_o(set_o), .sample_o(sample_o),
  .q(q_cur), .idle(is_idle), .fall(rx_fall), .tick(tq_tick)
);

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;
  localparam int PW = 4;
  localparam int IB = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] prescale = 4'd1;
  logic          rx_in = 1'b1;
  logic          set_o;
  logic          sample_o;

  int total = 0;
  int fails = 0;
  int n_q = 2;

  can_bit_timer #(.PRESC_W(PW), .IDLE_BITS(IB)) u0 (
    .clk(clk), .rst(rst), .prescale(prescale), .rx_in(rx_in),
    .set_o(set_o), .sample_o(sample_o)
  );

  always #10ns clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_set(output int n);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!set_o && n < 1000);
  endtask

  task automatic count_sample(output int n);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!sample_o && n < 1000);
  endtask

  task automatic sync_to_set();
    if (!set_o) begin
      do @(negedge clk); while (!set_o);
    end
  endtask

  task automatic drive_fall_at(input int x);
    repeat (x - 3) @(posedge clk);
    @(negedge clk);
    rx_in = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    rx_in = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R3 strobes low in reset", int'(set_o) + int'(sample_o), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R3 strobes low after release", int'(set_o) + int'(sample_o), 0);
  endtask

  task automatic t_period(input int p);
    int a, b;
    prescale = PW'(p);
    n_q = p + 1;
    sync_to_set();
    count_set(a);
    count_sample(a);
    check("R2 set to sample", a, 7 * n_q);
    count_set(b);
    check("R1 sample to set", b, 3 * n_q);
    @(negedge clk);
    check("R2 set one clock", int'(set_o), 0);
  endtask

  task automatic t_hard_sync();
    int n;
    sync_to_set();
    drive_fall_at(3 * n_q + 1);
    count_set(n);
    check("R4 R5 hard restart latency", n, 3);
    count_sample(n);
    check("R5 sample after restart", n, 7 * n_q);
    rx_in = 1'b1;
    count_set(n);
    check("R4 rise ignored", n, 3 * n_q);
  endtask

  task automatic t_late(input int e);
    int n;
    sync_to_set();
    drive_fall_at(e * n_q + 1);
    count_sample(n);
    check($sformatf("R6 late edge q%0d", e), n, 3 + (8 - e) * n_q);
    rx_in = 1'b1;
    count_set(n);
    check("R6 bit after late edge", n, 3 * n_q);
  endtask

  task automatic t_early9();
    int n;
    sync_to_set();
    drive_fall_at(9 * n_q + 1);
    count_set(n);
    check("R7 early edge q9 wraps", n, 3);
    count_sample(n);
    check("R7 sample after wrap", n, 7 * n_q);
    rx_in = 1'b1;
    count_set(n);
    check("R7 bit after wrap", n, 3 * n_q);
  endtask

  task automatic t_early8();
    int n;
    sync_to_set();
    drive_fall_at(8 * n_q + 1);
    count_set(n);
    check("R7 early edge q8", n, 3 + n_q);
    count_sample(n);
    check("R7 sample after q8 edge", n, 7 * n_q);
    rx_in = 1'b1;
    count_set(n);
    check("R7 bit after q8 edge", n, 3 * n_q);
  endtask

  task automatic t_q0();
    int n;
    sync_to_set();
    drive_fall_at(10 * n_q + 1);
    count_sample(n);
    check("R8 edge in q0 no effect", n, 7 * n_q + 2);
    rx_in = 1'b1;
    count_set(n);
    check("R8 bit after q0 edge", n, 3 * n_q);
  endtask

  task automatic t_idle_again();
    int n;
    rx_in = 1'b1;
    repeat (IB) count_sample(n);
    sync_to_set();
    drive_fall_at(3 * n_q + 1);
    count_set(n);
    check("R9 idle again hard restart", n, 3);
    count_sample(n);
    check("R9 R5 sample after restart", n, 7 * n_q);
    rx_in = 1'b1;
    count_set(n);
    check("R9 bit after restart", n, 3 * n_q);
  endtask

  initial begin
    t_reset();
    t_period(1);
    t_period(3);
    t_period(0);
    t_period(1);
    t_hard_sync();
    t_late(3);
    t_late(1);
    t_late(6);
    t_early9();
    t_early8();
    t_q0();
    t_idle_again();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #4ms;
    total++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule